// File: doc/BRIEF.md
# Fine-Resolution PWM Timebase

This block produces a raw pulse-width-modulated level and a one-clock marker at the start of every period. A base-clock prescaler (divide by 1, 4 or 16) paces a two-bit quarter counter. Each wrap of the quarter counter advances an 8-bit period counter. The period is therefore set in steps of four prescaled clocks. The duty value is 10 bits wide and is compared against the period counter joined with the quarter counter. This makes duty resolution four times finer than period resolution.

Software-side logic writes the period, duty and prescale values through plain write-enable ports. These values go into holding registers. They are copied into the active set only when a period ends, so a period in progress is never disturbed. Downstream steering logic (bridge or dead-band stages) takes `pwm_out` and uses `period_start` to align with each new period. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure. Every input and output is a plain control pin.

Top module: `pwmtb_top`

## Requirements
- R1: While reset is held and right after it, `pwm_out` and `period_start` are 0. The reset settings are period value 0, duty 0 and divide-by-1, which give a 4-clock period with the output low.
- R2: Consecutive `period_start` pulses are exactly 4 × (period value + 1) × F clocks apart, where F is the prescale factor.
- R3: The prescale code is decoded as 2'b00 → F=1, 2'b01 → F=4, 2'b10 → F=16 and 2'b11 → F=16.
- R4: When 0 < duty < 4 × (period value + 1), `pwm_out` is high from the first clock of the period for exactly duty × F clocks. It then stays low until the next period starts.
- R5: When duty ≥ 4 × (period value + 1), `pwm_out` stays high for the whole period.
- R6: When duty is 0, `pwm_out` stays low for the whole period.
- R7: A period, duty or prescale write takes effect only in the period that begins after the write. The period in progress keeps its length and its high time.
- R8: `period_start` is a single-clock pulse. It is high in the first clock of every new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| per_we | input | 1 | Write strobe for the period value |
| per_wdata | input | 8 | Period value (period counter terminal count) |
| duty_we | input | 1 | Write strobe for the duty value |
| duty_wdata | input | 10 | Duty value: upper 8 bits compare with the period counter, lower 2 bits with the quarter count |
| psc_we | input | 1 | Write strobe for the prescale code |
| psc_wdata | input | 2 | Prescale code (see R3) |
| pwm_out | output | 1 | Raw PWM level |
| period_start | output | 1 | One-clock pulse in the first clock of each period |

## Verification
A fault in the prescaler or the quarter counter shows up as a wrong spacing between `period_start` pulses. It appears within the very next period, no later than about 16 thousand clocks. An active duty or period register that was latched at the wrong moment shows up as a wrong high count. It is caught in the period right after the write, or in the same period if a mid-period write leaks through. A comparison off by one step changes the high time by F clocks. An off-range duty that is mishandled leaves the output low, or low for one step, at the end of the period. Both are visible in the period they occur in.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
  localparam int PRE_W = 4;

  typedef enum logic [1:0] {
    PSC_DIV1     = 2'b00,
    PSC_DIV4     = 2'b01,
    PSC_DIV16    = 2'b10,
    PSC_DIV16_HI = 2'b11
  } psc_sel_e;

  // last prescaler count before a fine step is issued
  function automatic logic [PRE_W-1:0] psc_last(psc_sel_e sel);
    case (sel)
      PSC_DIV1: return PRE_W'(0);
      PSC_DIV4: return PRE_W'(3);
      default:  return PRE_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/pwmtb_regs.sv
module pwmtb_regs
  import pwmtb_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_we,
  input  logic [CNT_W-1:0]  per_wdata,
  input  logic              duty_we,
  input  logic [DUTY_W-1:0] duty_wdata,
  input  logic              psc_we,
  input  logic [1:0]        psc_wdata,
  input  logic              load,
  output logic [CNT_W-1:0]  per_sh,
  output logic [DUTY_W-1:0] duty_sh,
  output psc_sel_e          psc_sh
);
  logic [CNT_W-1:0]  per_hold;
  logic [DUTY_W-1:0] duty_hold;
  psc_sel_e          psc_hold;

  // holding registers: written at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_hold  <= '0;
      duty_hold <= '0;
      psc_hold  <= PSC_DIV1;
    end else begin
      if (per_we)  per_hold  <= per_wdata;
      if (duty_we) duty_hold <= duty_wdata;
      if (psc_we)  psc_hold  <= psc_sel_e'(psc_wdata);
    end
  end

  // active registers: copied only when a period ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh  <= '0;
      duty_sh <= '0;
      psc_sh  <= PSC_DIV1;
    end else if (load) begin
      per_sh  <= per_hold;
      duty_sh <= duty_hold;
      psc_sh  <= psc_hold;
    end
  end
endmodule

// File: rtl/pwmtb_prescale.sv
module pwmtb_prescale
  import pwmtb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  psc_sel_e sel,
  output logic     step
);
  logic [PRE_W-1:0] pre_q;

  assign step = (pre_q == psc_last(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (step) pre_q <= '0;
    else           pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/pwmtb_timebase.sv
module pwmtb_timebase #(
  parameter int CNT_W = 8,
  parameter int SUB_W = 2,
  localparam int POS_W = CNT_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] per_sh,
  output logic [CNT_W-1:0] cnt_q,
  output logic [POS_W-1:0] fine_pos,
  output logic             wrap
);
  logic [SUB_W-1:0] sub_q;
  logic             sub_roll;

  assign sub_roll = step && (&sub_q);
  assign wrap     = sub_roll && (cnt_q == per_sh);
  assign fine_pos = {cnt_q, sub_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      cnt_q <= '0;
    end else if (step) begin
      sub_q <= sub_q + SUB_W'(1);
      if (wrap)          cnt_q <= '0;
      else if (sub_roll) cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pwmtb_cmp.sv
module pwmtb_cmp #(
  parameter int DUTY_W = 10
) (
  input  logic [DUTY_W-1:0] fine_pos,
  input  logic [DUTY_W-1:0] duty_sh,
  output logic              level
);
  // active while the fine position is still below the duty value
  assign level = (fine_pos < duty_sh);
endmodule

// File: rtl/pwmtb_top.sv
module pwmtb_top
  import pwmtb_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SUB_W  = 2,
  localparam int DUTY_W = CNT_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_we,
  input  logic [CNT_W-1:0]  per_wdata,
  input  logic              duty_we,
  input  logic [DUTY_W-1:0] duty_wdata,
  input  logic              psc_we,
  input  logic [1:0]        psc_wdata,
  output logic              pwm_out,
  output logic              period_start
);
  logic [CNT_W-1:0]  per_sh;
  logic [DUTY_W-1:0] duty_sh;
  psc_sel_e          psc_sh;
  logic              step;
  logic              wrap;
  logic [CNT_W-1:0]  cnt_q;
  logic [DUTY_W-1:0] fine_pos;
  logic              strobe_q;

  pwmtb_regs #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .per_we(per_we), .per_wdata(per_wdata),
    .duty_we(duty_we), .duty_wdata(duty_wdata),
    .psc_we(psc_we), .psc_wdata(psc_wdata),
    .load(wrap),
    .per_sh(per_sh), .duty_sh(duty_sh), .psc_sh(psc_sh)
  );

  pwmtb_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .sel(psc_sh), .step(step)
  );

  pwmtb_timebase #(.CNT_W(CNT_W), .SUB_W(SUB_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .step(step), .per_sh(per_sh),
    .cnt_q(cnt_q), .fine_pos(fine_pos), .wrap(wrap)
  );

  pwmtb_cmp #(.DUTY_W(DUTY_W)) u_cmp (
    .fine_pos(fine_pos), .duty_sh(duty_sh), .level(pwm_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= wrap;
  end

  assign period_start = strobe_q;
endmodule

// File: rtl/pwmtb_chk.sv
module pwmtb_chk #(
  parameter int CNT_W  = 8,
  parameter int DUTY_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_out,
  input logic              period_start,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  per_sh,
  input logic [DUTY_W-1:0] duty_sh
);
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_sh);

  p_start_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && duty_sh != '0) |-> pwm_out);

  p_no_midrise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> period_start);

  p_full_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_sh > {per_sh, 2'b11}) |-> pwm_out);

  p_zero_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_sh == '0) |-> !pwm_out);

  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> ($stable(duty_sh) && $stable(per_sh)));

  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);
endmodule

bind pwmtb_top pwmtb_chk #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .period_start(period_start),
  .cnt(cnt_q), .per_sh(per_sh), .duty_sh(duty_sh)
);

// File: tb/pwmtb_top_tb.sv
module pwmtb_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       per_we = 1'b0, duty_we = 1'b0, psc_we = 1'b0;
  logic [7:0] per_wdata = '0;
  logic [9:0] duty_wdata = '0;
  logic [1:0] psc_wdata = '0;
  logic       pwm_out, period_start;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pwmtb_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .per_we(per_we), .per_wdata(per_wdata),
    .duty_we(duty_we), .duty_wdata(duty_wdata),
    .psc_we(psc_we), .psc_wdata(psc_wdata),
    .pwm_out(pwm_out), .period_start(period_start)
  );

  function automatic int f_of(int psc);       // R3
    case (psc)
      0: return 1;
      1: return 4;
      default: return 16;
    endcase
  endfunction

  function automatic int exp_len(int per, int psc);   // R2
    return 4 * (per + 1) * f_of(psc);
  endfunction

  function automatic int exp_hi(int duty, int per, int psc);  // R4 R5 R6
    int steps = 4 * (per + 1);
    return ((duty < steps) ? duty : steps) * f_of(psc);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_all(int per, int duty, int psc);
    per_we = 1'b1; per_wdata = 8'(per);
    duty_we = 1'b1; duty_wdata = 10'(duty);
    psc_we = 1'b1; psc_wdata = 2'(psc);
    @(negedge clk);
    per_we = 1'b0; duty_we = 1'b0; psc_we = 1'b0;
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!period_start);
  endtask

  // called at a negedge where period_start is high; ends at the next such negedge
  task automatic measure(output int len, output int hi, output bit first_hi,
                         output bit width_ok, output bit shape_ok);
    bit seen_low = 1'b0;
    len = 0; hi = 0; first_hi = pwm_out; width_ok = 1'b1; shape_ok = 1'b1;
    do begin
      if (pwm_out) begin
        hi++;
        if (seen_low) shape_ok = 1'b0;
      end else seen_low = 1'b1;
      len++;
      @(negedge clk);
      if (len == 1 && period_start) width_ok = 1'b0;
    end while (!period_start);
  endtask

  task automatic run_case(int per, int duty, int psc, string tag);
    int len, hi;
    bit fh, wok, sok;
    wr_all(per, duty, psc);
    wait_start();
    measure(len, hi, fh, wok, sok);
    check(len == exp_len(per, psc), {tag, " R2/R3 period length"}, len, exp_len(per, psc));
    if (duty == 0)
      check(hi == 0, {tag, " R6 zero duty high count"}, hi, 0);
    else if (duty >= 4 * (per + 1))
      check(hi == len, {tag, " R5 full duty high count"}, hi, len);
    else
      check(hi == exp_hi(duty, per, psc), {tag, " R4 high count"}, hi, exp_hi(duty, per, psc));
    check(fh == (duty != 0), {tag, " R4 level in first clock"}, int'(fh), int'(duty != 0));
    check(sok, {tag, " R4 single pulse per period"}, int'(sok), 1);
    check(wok, {tag, " R8 start strobe width"}, int'(wok), 1);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int len, hi, h0;
    bit fh, wok, sok;
    int unsigned seed;
    seed = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R1 pwm low in reset", int'(pwm_out), 0);
    check(period_start == 1'b0, "R1 strobe low in reset", int'(period_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out == 1'b0, "R1 pwm low after reset", int'(pwm_out), 0);

    // defaults: 4-clock period, output low
    wait_start();
    measure(len, hi, fh, wok, sok);
    check(len == 4, "R1 default period", len, 4);
    check(hi == 0, "R1 default duty", hi, 0);

    // directed corners
    run_case(255, 1023, 0, "max");
    run_case(0, 3, 2, "tiny3");
    run_case(0, 4, 1, "tinyfull");
    run_case(10, 0, 3, "zero");
    run_case(5, 1, 3, "code3");
    run_case(7, 1023, 1, "over");

    // R7: mid-period duty write leaves the running period alone
    wr_all(20, 40, 0);
    wait_start();
    wait_start();
    h0 = int'(pwm_out);
    duty_we = 1'b1; duty_wdata = 10'd10;
    @(negedge clk);
    duty_we = 1'b0;
    hi = h0; len = 1;
    while (!period_start) begin
      if (pwm_out) hi++;
      len++;
      @(negedge clk);
    end
    check(hi == 40, "R7 running period keeps old duty", hi, 40);
    check(len == 84, "R7 running period keeps length", len, 84);
    measure(len, hi, fh, wok, sok);
    check(hi == 10, "R7 next period uses new duty", hi, 10);

    // R7: period write mid-period
    wait_start();
    per_we = 1'b1; per_wdata = 8'd3;
    @(negedge clk);
    per_we = 1'b0;
    len = 1;
    while (!period_start) begin len++; @(negedge clk); end
    check(len == 84, "R7 running period keeps old period", len, 84);
    measure(len, hi, fh, wok, sok);
    check(len == 16, "R7 new period applied", len, 16);

    // constrained random
    for (int i = 0; i < 16; i++) begin
      int per  = int'($urandom % 32);
      int psc  = int'($urandom % 4);
      int duty = int'($urandom % (4 * (per + 1) + 8));
      run_case(per, duty, psc, "rand");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule